// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus and turns a single request into the full bus conversation that a standard single-supply flash expects. A request asks for one of three operations: write one byte, clear one sector, or clear the whole array. The block sends the two unlock writes and the command writes, then watches the device's status byte until the operation settles. It finishes with a one-cycle done pulse and a pass flag.

The block does not rely on a ready/busy pin. It reads the target location repeatedly and compares one status bit between consecutive reads. While that bit keeps flipping, the device is still working. When two reads agree, one further read confirms that the bit has really stopped. The block then reads the location once more as data and checks it: for a write it must equal the requested byte, and for an erase it must be all ones. A per-request limit on the number of busy observations keeps a stuck device from hanging the host.

Bus timing is counted in whole clock cycles. Each bus access has one setup cycle with chip enable low, a strobe held low for a parameter-set number of cycles, and one hold cycle. Between accesses there is one idle cycle with chip enable high.

Top module: `fpe_ctrl`

## Requirements
- R1: After reset, req_ready is 1, fl_ce_n, fl_oe_n and fl_we_n are 1, and fl_doe and done are 0.
- R2: A request with req_op = 0 (byte write) produces exactly four bus writes, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then req_addr/req_data.
- R3: A request with req_op = 1 (sector clear) produces exactly six bus writes, in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then req_addr/0x30.
- R4: A request with req_op = 2 (array clear) produces the same first five writes as R3 and ends with 0x555/0x10.
- R5: During a bus write, fl_ce_n is low, fl_we_n stays low for exactly WR_LOW cycles, and fl_addr and fl_dout do not change from the falling edge of fl_we_n through the cycle in which it rises. fl_oe_n and fl_we_n are never low together.
- R6: After the command writes, status is read at req_addr in pairs. If bit 6 differs between the two reads of a pair, that is one busy observation, and a new pair follows.
- R7: When a pair agrees on bit 6, one more read follows. If its bit 6 equals the second read of the pair, the operation counts as settled. Otherwise that is one busy observation, and a new pair follows.
- R8: Once the operation settles, one more read at req_addr decides the result. A byte write passes only if that read equals req_data. An erase passes only if it equals 0xFF.
- R9: poll_limit is captured when the request is accepted. When the count of busy observations reaches the larger of poll_limit and 1, done is raised with pass = 0 and no further read is made.
- R10: done is high for exactly one cycle, and pass is meaningful only while done is high. A request is accepted when req_valid and req_ready are both high. req_ready stays low from the cycle after acceptance until the cycle after done.
- R11: A request with req_op = 3 makes no bus access. It raises done with pass = 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_op | input | 2 | 0 byte write, 1 sector clear, 2 array clear, 3 invalid |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to write (used by op 0 only) |
| poll_limit | input | PW | Maximum number of busy observations |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid while done is high |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Write data to the flash |
| fl_doe | output | 1 | Host drives the data bus |
| fl_din | input | 8 | Read data from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the block with WR_LOW = 3 and RD_LOW = 2. These values are unequal and larger than one, so a wrong write strobe width, or a mix-up between the read and write counts, shows up as a wrong strobe width. PW = 4 keeps poll limits small, so the bench can reach the timeout exit with a short scripted status stream, and can also test poll_limit = 0. The flash model in the bench can also replay a scripted status sequence. With this it can produce a pair that agrees followed by a confirming read that disagrees, a pattern a plain memory model would never give.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  localparam int FPE_DW   = 8;   // flash data width
  localparam int FPE_CAW  = 12;  // width of command-cycle addresses
  localparam int FPE_TBIT = 6;   // status bit that flips while busy

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_BAD    = 2'd3
  } fpe_op_e;

  // One command write: tgt selects the request address, usr selects the request data
  typedef struct packed {
    logic               tgt;
    logic               usr;
    logic [FPE_CAW-1:0] addr;
    logic [FPE_DW-1:0]  data;
  } fpe_step_t;

  function automatic logic [2:0] seq_len(fpe_op_e op);
    case (op)
      OP_PROG:   return 3'd4;
      OP_SERASE: return 3'd6;
      OP_CERASE: return 3'd6;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic fpe_step_t step_of(fpe_op_e op, logic [2:0] idx);
    fpe_step_t s;
    s = '{tgt: 1'b0, usr: 1'b0, addr: '0, data: '0};
    case (idx)
      3'd0, 3'd3: begin
        s.addr = 12'h555;
        s.data = 8'hAA;
        if (idx == 3'd3 && op == OP_PROG) begin
          s.tgt = 1'b1;
          s.usr = 1'b1;
        end
      end
      3'd1, 3'd4: begin
        s.addr = 12'h2AA;
        s.data = 8'h55;
      end
      3'd2: begin
        s.addr = 12'h555;
        s.data = (op == OP_PROG) ? 8'hA0 : 8'h80;
      end
      3'd5: begin
        if (op == OP_SERASE) begin
          s.tgt  = 1'b1;
          s.data = 8'h30;
        end else begin
          s.addr = 12'h555;
          s.data = 8'h10;
        end
      end
      default: s.data = 8'h00;
    endcase
    return s;
  endfunction

  function automatic logic bit_flip(logic [FPE_DW-1:0] a, logic [FPE_DW-1:0] b);
    return a[FPE_TBIT] ^ b[FPE_TBIT];
  endfunction

  function automatic logic verify_ok(fpe_op_e op, logic [FPE_DW-1:0] got,
                                     logic [FPE_DW-1:0] want);
    if (op == OP_PROG) return got == want;
    return got == {FPE_DW{1'b1}};
  endfunction

endpackage

// File: rtl/fpe_bus_cycle.sv
module fpe_bus_cycle #(
  parameter int AW     = 17,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      wr,
  input  logic [AW-1:0]             addr_i,
  input  logic [fpe_pkg::FPE_DW-1:0] wdata_i,
  output logic                      idle,
  output logic                      ack,
  output logic [fpe_pkg::FPE_DW-1:0] rdata,
  output logic [AW-1:0]             bus_addr,
  output logic [fpe_pkg::FPE_DW-1:0] bus_dout,
  output logic                      bus_doe,
  input  logic [fpe_pkg::FPE_DW-1:0] bus_din,
  output logic                      ce_n,
  output logic                      oe_n,
  output logic                      we_n
);
  localparam int MAXL = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int CW   = $clog2(MAXL + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STRB, B_HOLD} bus_st_e;

  bus_st_e                     st_q;
  logic [CW-1:0]               cnt_q;
  logic                        wr_q;
  logic [AW-1:0]               addr_q;
  logic [fpe_pkg::FPE_DW-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (start) begin
          wr_q   <= wr;
          addr_q <= addr_i;
          data_q <= wdata_i;
          st_q   <= B_SETUP;
        end
        B_SETUP: begin
          cnt_q <= wr_q ? CW'(WR_LOW - 1) : CW'(RD_LOW - 1);
          st_q  <= B_STRB;
        end
        B_STRB: begin
          if (cnt_q == '0) begin
            if (!wr_q) rdata <= bus_din;
            st_q <= B_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign idle     = (st_q == B_IDLE);
  assign ack      = (st_q == B_HOLD);
  assign ce_n     = (st_q == B_IDLE);
  assign we_n     = !((st_q == B_STRB) && wr_q);
  assign oe_n     = !((st_q == B_STRB) && !wr_q);
  assign bus_doe  = wr_q && (st_q != B_IDLE);
  assign bus_addr = addr_q;
  assign bus_dout = data_q;

endmodule

// File: rtl/fpe_toggle_cmp.sv
module fpe_toggle_cmp (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [fpe_pkg::FPE_DW-1:0] cur,
  output logic                       flip
);
  logic [fpe_pkg::FPE_DW-1:0] ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '0;
    else if (load) ref_q <= cur;
  end

  assign flip = fpe_pkg::bit_flip(ref_q, cur);

endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import fpe_pkg::*;
#(
  parameter int AW     = 17,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 2,
  parameter int PW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic [FPE_DW-1:0] req_data,
  input  logic [PW-1:0]     poll_limit,
  output logic              done,
  output logic              pass,
  output logic [AW-1:0]     fl_addr,
  output logic [FPE_DW-1:0] fl_dout,
  output logic              fl_doe,
  input  logic [FPE_DW-1:0] fl_din,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n
);

  typedef enum logic [2:0] {
    T_IDLE, T_CMD, T_POLL_A, T_POLL_B, T_RECHK, T_VERIFY, T_FINISH
  } seq_st_e;

  seq_st_e           st_q;
  fpe_op_e           op_q;
  logic [AW-1:0]     addr_q;
  logic [FPE_DW-1:0] data_q;
  logic [PW-1:0]     limit_q;
  logic [PW-1:0]     busy_q;
  logic [2:0]        step_q;
  logic              pass_q;

  fpe_step_t         cur_step;
  logic              eng_start, eng_wr, eng_idle, eng_ack;
  logic [AW-1:0]     eng_addr;
  logic [FPE_DW-1:0] eng_wdata, eng_rdata;
  logic              flip, tog_load;
  logic [PW:0]       busy_nxt;
  logic              exhausted;
  logic              accept;

  // named events for the checker
  logic ev_cmd_wr, ev_busy, ev_timeout, ev_settled, ev_verify;

  assign accept    = req_valid && req_ready;
  assign req_ready = (st_q == T_IDLE);
  assign cur_step  = step_of(op_q, step_q);
  assign eng_wr    = (st_q == T_CMD);
  assign eng_addr  = (eng_wr && !cur_step.tgt) ? AW'(cur_step.addr) : addr_q;
  assign eng_wdata = cur_step.usr ? data_q : cur_step.data;
  assign eng_start = eng_idle &&
                     (st_q inside {T_CMD, T_POLL_A, T_POLL_B, T_RECHK, T_VERIFY});

  assign busy_nxt  = {1'b0, busy_q} + 1'b1;
  assign exhausted = busy_nxt >= {1'b0, limit_q};

  assign ev_cmd_wr  = eng_ack && (st_q == T_CMD);
  assign ev_busy    = eng_ack && (st_q == T_POLL_B || st_q == T_RECHK) && flip;
  assign ev_timeout = ev_busy && exhausted;
  assign ev_settled = eng_ack && (st_q == T_RECHK) && !flip;
  assign ev_verify  = eng_ack && (st_q == T_VERIFY);
  assign tog_load   = eng_ack && (st_q == T_POLL_A || st_q == T_POLL_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= T_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      limit_q <= '0;
      busy_q  <= '0;
      step_q  <= '0;
      pass_q  <= 1'b0;
    end else begin
      case (st_q)
        T_IDLE: if (accept) begin
          op_q    <= fpe_op_e'(req_op);
          addr_q  <= req_addr;
          data_q  <= req_data;
          limit_q <= poll_limit;
          busy_q  <= '0;
          step_q  <= '0;
          pass_q  <= 1'b0;
          st_q    <= (fpe_op_e'(req_op) == OP_BAD) ? T_FINISH : T_CMD;
        end
        T_CMD: if (ev_cmd_wr) begin
          if (step_q == seq_len(op_q) - 3'd1) begin
            step_q <= '0;
            st_q   <= T_POLL_A;
          end else begin
            step_q <= step_q + 3'd1;
          end
        end
        T_POLL_A: if (eng_ack) st_q <= T_POLL_B;
        T_POLL_B, T_RECHK: begin
          if (ev_timeout) begin
            st_q <= T_FINISH;
          end else if (ev_busy) begin
            busy_q <= busy_nxt[PW-1:0];
            st_q   <= T_POLL_A;
          end else if (ev_settled) begin
            st_q <= T_VERIFY;
          end else if (eng_ack) begin
            st_q <= T_RECHK;
          end
        end
        T_VERIFY: if (ev_verify) begin
          pass_q <= verify_ok(op_q, eng_rdata, data_q);
          st_q   <= T_FINISH;
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign done = (st_q == T_FINISH);
  assign pass = pass_q && done;

  fpe_bus_cycle #(.AW(AW), .WR_LOW(WR_LOW), .RD_LOW(RD_LOW)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .wr       (eng_wr),
    .addr_i   (eng_addr),
    .wdata_i  (eng_wdata),
    .idle     (eng_idle),
    .ack      (eng_ack),
    .rdata    (eng_rdata),
    .bus_addr (fl_addr),
    .bus_dout (fl_dout),
    .bus_doe  (fl_doe),
    .bus_din  (fl_din),
    .ce_n     (fl_ce_n),
    .oe_n     (fl_oe_n),
    .we_n     (fl_we_n)
  );

  fpe_toggle_cmp u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tog_load),
    .cur   (eng_rdata),
    .flip  (flip)
  );

endmodule

// File: rtl/fpe_ctrl_chk.sv
module fpe_ctrl_chk #(
  parameter int AW     = 17,
  parameter int WR_LOW = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [1:0]                 req_op,
  input logic                       done,
  input logic                       pass,
  input logic [AW-1:0]              fl_addr,
  input logic [fpe_pkg::FPE_DW-1:0] fl_dout,
  input logic                       fl_doe,
  input logic                       fl_ce_n,
  input logic                       fl_oe_n,
  input logic                       fl_we_n,
  input logic                       ev_timeout
);
  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= 0;
    else if (!fl_we_n) low_run <= low_run + 1;
    else               low_run <= 0;
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n));

  a_r5_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n && fl_doe);

  a_r5_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr) && $stable(fl_dout));

  a_r5_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> !fl_ce_n && fl_doe && $stable(fl_addr) && $stable(fl_dout));

  a_r5_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> low_run == WR_LOW);

  a_r6_read_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_ce_n && !fl_doe);

  a_r9_timeout_fail: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> done && !pass);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_pass_qual: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  a_r11_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd3) |=> done && !pass && fl_ce_n);

endmodule

bind fpe_ctrl fpe_ctrl_chk #(.AW(AW), .WR_LOW(WR_LOW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .done       (done),
  .pass       (pass),
  .fl_addr    (fl_addr),
  .fl_dout    (fl_dout),
  .fl_doe     (fl_doe),
  .fl_ce_n    (fl_ce_n),
  .fl_oe_n    (fl_oe_n),
  .fl_we_n    (fl_we_n),
  .ev_timeout (ev_timeout)
);

// File: tb/fpe_ctrl_tb.sv
module fpe_ctrl_tb;
  localparam int AW  = 17;
  localparam int WRL = 3;
  localparam int RDL = 2;
  localparam int PW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic [PW-1:0] poll_limit = '0;
  logic          done, pass;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dout;
  logic          fl_doe;
  logic [7:0]    fl_din = 8'h00;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fpe_ctrl #(.AW(AW), .WR_LOW(WRL), .RD_LOW(RDL), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .poll_limit(poll_limit), .done(done), .pass(pass), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_doe(fl_doe), .fl_din(fl_din), .fl_ce_n(fl_ce_n),
    .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural flash model
  logic [7:0] mem [int];
  logic [7:0] resp_q [$];
  int         wlog_a [$];
  int         wlog_d [$];
  int         rd_count = 0;
  int         cur_tgt = 0;
  bit         prev_we = 1'b1;
  bit         rd_active = 1'b0;
  bit         prog_armed = 1'b0;
  int         low_len = 0;
  int         fall_a = 0;
  int         fall_d = 0;

  function automatic logic [7:0] mem_rd(int a);
    if (mem.exists(a)) return mem[a];
    return 8'hFF;
  endfunction

  task automatic apply_write(int a, int d);
    int keys [$];
    if (prog_armed) begin
      mem[a] = mem_rd(a) & d[7:0];
      prog_armed = 1'b0;
    end else if (a == 'h555 && d == 'hA0) begin
      prog_armed = 1'b1;
    end else if (d == 'h30) begin
      foreach (mem[k]) if ((k >> 12) == (a >> 12)) keys.push_back(k);
      foreach (keys[i]) mem.delete(keys[i]);
    end else if (a == 'h555 && d == 'h10) begin
      mem.delete();
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we = 1'b1;
      rd_active = 1'b0;
    end else begin
      // bus invariants compared every clock (R5)
      chk(!(!fl_oe_n && !fl_we_n), "R5", "oe/we both low", 1, 0);
      if (!fl_we_n) begin
        chk(!fl_ce_n, "R5", "we low without ce", fl_ce_n, 0);
        if (prev_we) begin
          low_len = 1;
          fall_a = int'(fl_addr);
          fall_d = int'(fl_dout);
        end else begin
          low_len++;
          chk(int'(fl_addr) == fall_a && int'(fl_dout) == fall_d, "R5",
              "addr/data moved while we low", int'(fl_addr), fall_a);
        end
      end else if (!prev_we) begin
        chk(low_len == WRL, "R5", "we low width", low_len, WRL);
        chk(int'(fl_addr) == fall_a && int'(fl_dout) == fall_d && !fl_ce_n, "R5",
            "hold after we rise", int'(fl_addr), fall_a);
        wlog_a.push_back(int'(fl_addr));
        wlog_d.push_back(int'(fl_dout));
        apply_write(int'(fl_addr), int'(fl_dout));
      end
      prev_we = fl_we_n;
      if (!fl_oe_n && !rd_active) begin
        rd_active = 1'b1;
        rd_count++;
        chk(int'(fl_addr) == cur_tgt, "R6", "status read address", int'(fl_addr), cur_tgt);
        if (resp_q.size() > 0) fl_din = resp_q.pop_front();
        else                   fl_din = mem_rd(int'(fl_addr));
      end
      if (fl_oe_n) rd_active = 1'b0;
    end
  end

  // independent prediction of read count and result
  task automatic predict(input int op, input logic [7:0] d, input int limit,
                         input logic [7:0] post, output int nreads, output bit ok);
    int idx = 0;
    int busy = 0;
    int lim;
    logic [7:0] r [3];
    bit fin = 1'b0;
    lim = (limit < 1) ? 1 : limit;
    nreads = 0;
    ok = 1'b0;
    for (int it = 0; it < 64 && !fin; it++) begin
      for (int k = 0; k < 3; k++) begin
        if (k == 2 && r[0][6] != r[1][6]) break;
        nreads++;
        if (idx < resp_q.size()) begin r[k] = resp_q[idx]; idx++; end
        else r[k] = post;
      end
      if (r[0][6] != r[1][6] || r[2][6] != r[1][6]) begin
        busy++;
        if (busy >= lim) fin = 1'b1;
      end else begin
        nreads++;
        ok = (op == 0) ? (post == d) : (post == 8'hFF);
        fin = 1'b1;
      end
    end
  endtask

  task automatic run_op(input logic [1:0] op, input int a, input logic [7:0] d,
                        input int lim, input string rq_w, input string rq_r);
    int exp_a [$];
    int exp_d [$];
    int exp_reads;
    bit exp_ok;
    logic [7:0] post;
    int waited = 0;
    if (op == 2'd0) post = mem_rd(a) & d;
    else            post = 8'hFF;
    if (op != 2'd3) predict(int'(op), d, lim, post, exp_reads, exp_ok);
    else begin exp_reads = 0; exp_ok = 1'b0; end
    if (op != 2'd3) begin
      exp_a = '{'h555, 'h2AA};
      exp_d = '{'hAA, 'h55};
      if (op == 2'd0) begin
        exp_a.push_back('h555); exp_d.push_back('hA0);
        exp_a.push_back(a);     exp_d.push_back(int'(d));
      end else begin
        exp_a.push_back('h555); exp_d.push_back('h80);
        exp_a.push_back('h555); exp_d.push_back('hAA);
        exp_a.push_back('h2AA); exp_d.push_back('h55);
        exp_a.push_back(op == 2'd1 ? a : 'h555);
        exp_d.push_back(op == 2'd1 ? 'h30 : 'h10);
      end
    end
    wlog_a.delete();
    wlog_d.delete();
    rd_count = 0;
    cur_tgt = a;
    req_op = op;
    req_addr = AW'(a);
    req_data = d;
    poll_limit = PW'(lim);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10", "ready after accept", req_ready, 0);
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
      if (!done) chk(!req_ready, "R10", "ready while busy", req_ready, 0);
    end
    chk(done == 1'b1, "R10", "done seen", done, 1);
    if (op == 2'd3) chk(waited == 0, "R11", "bad-op latency", waited, 0);
    chk(pass == exp_ok, rq_r, "pass flag", pass, exp_ok);
    chk(rd_count == exp_reads, "R6 R7", "read count", rd_count, exp_reads);
    chk(wlog_a.size() == exp_a.size(), rq_w, "write count", wlog_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < wlog_a.size(); i++) begin
      chk(wlog_a[i] == exp_a[i], rq_w, "write address", wlog_a[i], exp_a[i]);
      chk(wlog_d[i] == exp_d[i], rq_w, "write data", wlog_d[i], exp_d[i]);
    end
    @(negedge clk);
    chk(!done && req_ready, "R10", "done single pulse, ready back", done, 0);
    resp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(req_ready && fl_ce_n && fl_oe_n && fl_we_n && !fl_doe && !done, "R1",
        "reset outputs", {req_ready, fl_ce_n, fl_oe_n, fl_we_n, fl_doe, done}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && fl_ce_n && !done, "R1", "idle after reset", req_ready, 1);

    // R2 byte write: one busy pair, then settles; verify passes (R8)
    resp_q = '{8'h00, 8'h40, 8'h40, 8'h40, 8'h40};
    run_op(2'd0, 'h01234, 8'h5A, 5, "R2", "R8");
    // R8 byte write trying to raise cleared bits: verify fails
    run_op(2'd0, 'h01234, 8'hA5, 5, "R2", "R8");
    // R3 sector clear: recheck read disagrees once (R7), then passes
    resp_q = '{8'h00, 8'h40, 8'h40, 8'h40, 8'h00};
    run_op(2'd1, 'h01200, 8'h00, 5, "R3", "R7");
    // sector clear took effect: writing a new byte passes
    run_op(2'd0, 'h01234, 8'h3C, 3, "R2", "R8");
    // R4 array clear with poll limit 2 never settling: timeout (R9)
    resp_q = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    run_op(2'd2, 'h1F000, 8'h00, 2, "R4", "R9");
    // R9 poll limit zero behaves as one
    resp_q = '{8'h40, 8'h00};
    run_op(2'd0, 'h00010, 8'h11, 0, "R2", "R9");
    // R11 invalid op
    run_op(2'd3, 'h00020, 8'h77, 4, "R11", "R11");
    // R4 array clear that settles, then write all zeros at top address
    run_op(2'd2, 'h00100, 8'h00, 4, "R4", "R8");
    run_op(2'd0, 'h1FFFF, 8'h00, 4, "R2", "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule